// File: doc/BRIEF.md
# Serial-Broadcast Cellular Neural Network Grid Node

This block is one cell of a two-dimensional grid that evaluates a discrete-time cellular neural network with a radius-1 neighbourhood. There is no neighbourhood buffer. The node keeps exactly one value in a single holding register. It passes that value to one neighbour at a time while taking in the next value from the opposite neighbour. Every node in the grid follows the same fixed 10-step schedule in lockstep. As the values move step by step, each of the nine neighbourhood values passes through every node's register in a fixed order. Each value is multiplied by its template coefficient and accumulated in the cycle in which it is held.

A run is started with a pulse on `start`, which also captures the node's own input pixel, a template select and an iteration count. The first 10-step pass multiplies the input pixels by the control coefficients and adds the bias. The node keeps this constant. Each later pass multiplies the current outputs by the feedback coefficients and adds the stored constant. The node then passes the sum through a table-driven saturating output function. The own output fed into the first feedback pass is the own input pixel.

Coefficients sit in a local memory. The memory address is built from the template select, a control/feedback half flag and the step index. The memory is filled through a simple write port.

Top module: `cnn_node`

## Requirements
- R1: After reset, `busy` and `done` are 0, `y_out` is 0 and all four neighbour outputs are 0.
- R2: A `start` pulse while idle captures `u_in`, `n_iter` and `tmpl_sel`, and the first step begins on the next cycle. A `start` pulse while busy is ignored: it changes neither the result nor the timing.
- R3: A run consists of one constant pass followed by `n_iter` feedback passes of 10 steps each (steps 0 to 9). `busy` is high for exactly 10*(`n_iter`+1) cycles. `done` is high for one cycle, directly after the last step 9, and `y_out` holds the result in that cycle.
- R4: In steps 0 to 7 the holding register is driven on one neighbour output and all other outputs are 0. In the same step the register loads from the opposite neighbour input. The send direction by step is: 0 north, 1 east, 2 and 3 south, 4 and 5 west, 6 and 7 north. Outside steps 0 to 7, and while idle, all outputs are 0.
- R5: In steps 0 to 8 the node consumes the held value, in the order own, S, SW, W, NW, N, NE, E, SE. Step k uses coefficient index k.
- R6: The coefficient address is {`tmpl_sel`[5:0], half, index[3:0]}. Half 0 holds the control coefficients at indices 0 to 8 and the bias at index 9. Half 1 holds the feedback coefficients at indices 0 to 8. `tmpl_sel` picks one of 64 templates.
- R7: The constant pass computes C = sum(b_k*u_k) + bias once. Each feedback pass computes x = C + sum(a_k*y_k).
- R8: The own value in the first feedback pass is the captured own input pixel. In each later pass it is the node's own previous output.
- R9: The output is clamp(x >>> 6, -128, 127), with an arithmetic shift, read from a table.
- R10: With `n_iter` = 0, `done` follows the constant pass and `y_out` equals the own input pixel.
- R11: The accumulator holds any sum of 18 products of 8-bit signed operands plus the bias exactly, including sums whose intermediate values exceed 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, accepted only while idle |
| n_iter | input | 4 | Number of feedback passes |
| tmpl_sel | input | 6 | Template select |
| u_in | input | 8 | Own input pixel, signed |
| cw_en | input | 1 | Coefficient memory write enable |
| cw_addr | input | 11 | Coefficient memory write address |
| cw_data | input | 8 | Coefficient write data, signed |
| in_n | input | 8 | Value from north neighbour |
| in_e | input | 8 | Value from east neighbour |
| in_s | input | 8 | Value from south neighbour |
| in_w | input | 8 | Value from west neighbour |
| out_n | output | 8 | Value to north neighbour |
| out_e | output | 8 | Value to east neighbour |
| out_s | output | 8 | Value to south neighbour |
| out_w | output | 8 | Value to west neighbour |
| y_out | output | 8 | Node output, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench acts as the eight neighbours. It drives distinct junk values on the three inputs that must not be sampled in a step, so a wrong receive direction corrupts the sum, and it checks each step's send port against the value the schedule says is held. The bench goes after four corner cases:
- Two templates are loaded at different selects, so a wrong address split would read the other template's result.
- An extreme case needs more than 16 bits of accumulator before it cancels to a small result, so a narrow accumulator would give a wrong output.
- A saturated intermediate output feeds the next pass, so an output function that wraps instead of clamping would show a different final value.
- A zero iteration count and a `start` pulse in the middle of a run check that the pass sequencing neither miscounts nor restarts.

// File: rtl/cnn_node_pkg.sv
package cnn_node_pkg;

  typedef enum logic [1:0] {DIR_N = 2'd0, DIR_E = 2'd1, DIR_S = 2'd2, DIR_W = 2'd3} dir_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ctl_state_e;

  localparam logic [3:0] STEP_LAST_XFER = 4'd7;
  localparam logic [3:0] STEP_LAST_MAC  = 4'd8;
  localparam logic [3:0] STEP_FINAL     = 4'd9;

  // Direction the holding register travels in a given step (R4).
  function automatic dir_e tx_dir(input logic [3:0] step);
    case (step)
      4'd0:       tx_dir = DIR_N;
      4'd1:       tx_dir = DIR_E;
      4'd2, 4'd3: tx_dir = DIR_S;
      4'd4, 4'd5: tx_dir = DIR_W;
      default:    tx_dir = DIR_N;
    endcase
  endfunction

  // Neighbour the holding register loads from: opposite of the send side.
  function automatic dir_e rx_dir(input logic [3:0] step);
    case (tx_dir(step))
      DIR_N:   rx_dir = DIR_S;
      DIR_E:   rx_dir = DIR_W;
      DIR_S:   rx_dir = DIR_N;
      default: rx_dir = DIR_E;
    endcase
  endfunction

endpackage

// File: rtl/cnn_coef_mem.sv
module cnn_coef_mem #(
  parameter int DW    = 8,
  parameter int SEL_W = 6,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W+IDX_W:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] sel,
  input  logic             half,
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    rd_data
);
  localparam int AW    = SEL_W + 1 + IDX_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_addr;

  // Address generator: template base, control/feedback half, step index (R6).
  assign rd_addr = {sel, half, idx};
  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/cnn_mac.sv
module cnn_mac #(
  parameter int DW    = 8,
  parameter int ACC_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             first,
  input  logic [ACC_W-1:0] base,
  input  logic [DW-1:0]    val,
  input  logic [DW-1:0]    coef,
  output logic [ACC_W-1:0] acc
);
  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] prod_x;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] acc_q;

  always_comb begin
    prod   = $signed(val) * $signed(coef);
    prod_x = ACC_W'(prod);
    addend = first ? $signed(base) : acc_q;
    acc_d  = addend + prod_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R11: adding a product never wraps the accumulator.
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !((addend[ACC_W-1] == prod_x[ACC_W-1]) && (acc_d[ACC_W-1] != addend[ACC_W-1])));

endmodule

// File: rtl/cnn_disc_lut.sv
module cnn_disc_lut #(
  parameter int DW     = 8,
  parameter int ACC_W  = 21,
  parameter int SHIFT  = 6,
  parameter int LUT_AW = 9
) (
  input  logic [ACC_W-1:0] state,
  output logic [DW-1:0]    y
);
  localparam int LUT_N = 1 << LUT_AW;
  localparam int HALF  = LUT_N / 2;
  localparam int YMAX  = (1 << (DW - 1)) - 1;
  localparam int YMIN  = -(1 << (DW - 1));
  localparam logic signed [ACC_W-1:0] IMAX = ACC_W'(HALF - 1);
  localparam logic signed [ACC_W-1:0] IMIN = ACC_W'(-HALF);

  logic [DW-1:0] lut [LUT_N];

  // Table contents computed at elaboration: saturating linear map (R9).
  for (genvar g = 0; g < LUT_N; g++) begin : g_entry
    localparam int SV = (g >= HALF) ? g - LUT_N : g;
    localparam int YV = (SV > YMAX) ? YMAX : ((SV < YMIN) ? YMIN : SV);
    assign lut[g] = DW'(YV);
  end

  logic signed [ACC_W-1:0] scaled;
  logic [LUT_AW-1:0]       idx;

  always_comb begin
    scaled = $signed(state) >>> SHIFT;
    if (scaled > IMAX)      idx = IMAX[LUT_AW-1:0];
    else if (scaled < IMIN) idx = IMIN[LUT_AW-1:0];
    else                    idx = scaled[LUT_AW-1:0];
  end

  assign y = lut[idx];

endmodule

// File: rtl/cnn_node.sv
module cnn_node
  import cnn_node_pkg::*;
#(
  parameter int DW     = 8,
  parameter int SEL_W  = 6,
  parameter int IDX_W  = 4,
  parameter int ITER_W = 4,
  parameter int SHIFT  = 6,
  parameter int LUT_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] n_iter,
  input  logic [SEL_W-1:0]  tmpl_sel,
  input  logic [DW-1:0]     u_in,
  input  logic              cw_en,
  input  logic [SEL_W+IDX_W:0] cw_addr,
  input  logic [DW-1:0]     cw_data,
  input  logic [DW-1:0]     in_n,
  input  logic [DW-1:0]     in_e,
  input  logic [DW-1:0]     in_s,
  input  logic [DW-1:0]     in_w,
  output logic [DW-1:0]     out_n,
  output logic [DW-1:0]     out_e,
  output logic [DW-1:0]     out_s,
  output logic [DW-1:0]     out_w,
  output logic [DW-1:0]     y_out,
  output logic              busy,
  output logic              done
);
  localparam int ACC_W = 2 * DW + 5;

  ctl_state_e        st_q, st_d;
  logic [3:0]        step_q, step_d;
  logic              cpass_q, cpass_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [DW-1:0]     u_q, u_d;
  logic [DW-1:0]     h_q, h_d;
  logic [ACC_W-1:0]  const_q, const_d;
  logic [DW-1:0]     y_q, y_d;
  logic              done_q, done_d;

  logic [DW-1:0]     coef;
  logic [ACC_W-1:0]  acc;
  logic [DW-1:0]     lut_y;
  logic [DW-1:0]     rx_val;
  logic              run;
  logic              mac_en;

  assign run    = (st_q == ST_RUN);
  assign mac_en = run && (step_q <= STEP_LAST_MAC);

  cnn_coef_mem #(.DW(DW), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_mem (
    .clk     (clk),
    .wr_en   (cw_en),
    .wr_addr (cw_addr),
    .wr_data (cw_data),
    .sel     (sel_q),
    .half    (!cpass_q),
    .idx     (IDX_W'(step_q)),
    .rd_data (coef)
  );

  cnn_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mac_en),
    .first (step_q == 4'd0),
    .base  (cpass_q ? '0 : const_q),
    .val   (h_q),
    .coef  (coef),
    .acc   (acc)
  );

  cnn_disc_lut #(.DW(DW), .ACC_W(ACC_W), .SHIFT(SHIFT), .LUT_AW(LUT_AW)) u_lut (
    .state (acc),
    .y     (lut_y)
  );

  // Receive mux
  always_comb begin
    case (rx_dir(step_q))
      DIR_N:   rx_val = in_n;
      DIR_E:   rx_val = in_e;
      DIR_S:   rx_val = in_s;
      default: rx_val = in_w;
    endcase
  end

  // Send drivers
  always_comb begin
    out_n = '0;
    out_e = '0;
    out_s = '0;
    out_w = '0;
    if (run && (step_q <= STEP_LAST_XFER)) begin
      case (tx_dir(step_q))
        DIR_N:   out_n = h_q;
        DIR_E:   out_e = h_q;
        DIR_S:   out_s = h_q;
        default: out_w = h_q;
      endcase
    end
  end

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    cpass_d = cpass_q;
    iter_d  = iter_q;
    sel_d   = sel_q;
    u_d     = u_q;
    h_d     = h_q;
    const_d = const_q;
    y_d     = y_q;
    done_d  = 1'b0;
    if (!run) begin
      if (start) begin
        st_d    = ST_RUN;
        step_d  = 4'd0;
        cpass_d = 1'b1;
        iter_d  = n_iter;
        sel_d   = tmpl_sel;
        u_d     = u_in;
        h_d     = u_in;
      end
    end else begin
      if (step_q <= STEP_LAST_XFER) h_d = rx_val;
      if (step_q != STEP_FINAL) begin
        step_d = step_q + 4'd1;
      end else begin
        step_d = 4'd0;
        if (cpass_q) begin
          const_d = acc + ACC_W'($signed(coef));
          cpass_d = 1'b0;
          h_d     = u_q;
          if (iter_q == '0) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            y_d    = u_q;
          end
        end else begin
          y_d    = lut_y;
          h_d    = lut_y;
          iter_d = iter_q - 1'b1;
          if (iter_q == ITER_W'(1)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      cpass_q <= 1'b0;
      iter_q  <= '0;
      sel_q   <= '0;
      u_q     <= '0;
      h_q     <= '0;
      const_q <= '0;
      y_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      cpass_q <= cpass_d;
      iter_q  <= iter_d;
      sel_q   <= sel_d;
      u_q     <= u_d;
      h_q     <= h_d;
      const_q <= const_d;
      y_q     <= y_d;
      done_q  <= done_d;
    end
  end

  assign y_out = y_q;
  assign busy  = run;
  assign done  = done_q;

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_q != STEP_FINAL) |=> (busy && step_q == $past(step_q) + 4'd1));

  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_single_sender_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_n != '0, out_e != '0, out_s != '0, out_w != '0}) <= 1);

  assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({out_n, out_e, out_s, out_w} == '0));

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (sel_q == $past(sel_q) && u_q == $past(u_q)));

endmodule

// File: tb/cnn_node_tb_top.sv
module cnn_node_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] n_iter;
  logic [5:0] tmpl_sel;
  logic [7:0] u_in;
  logic       cw_en;
  logic [10:0] cw_addr;
  logic [7:0] cw_data;
  logic [7:0] in_n, in_e, in_s, in_w;
  logic [7:0] out_n, out_e, out_s, out_w;
  logic [7:0] y_out;
  logic       busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cnn_node dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_iter(n_iter), .tmpl_sel(tmpl_sel),
    .u_in(u_in), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w),
    .y_out(y_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_out(input int s);
    int v;
    v = s >>> 6;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  // 0=N 1=E 2=S 3=W per step, from R4
  function automatic int send_side(input int s);
    case (s)
      0: return 0;
      1: return 1;
      2, 3: return 2;
      4, 5: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic write_coef(input int addr, input int val);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 11'(addr); cw_data = 8'(val);
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  // R6: control half {sel,0,idx}, bias at idx 9, feedback half {sel,1,idx}
  task automatic load_tmpl(input int sel, input int b[9], input int bias, input int a[9]);
    for (int k = 0; k < 9; k++) begin
      write_coef(sel * 32 + k, b[k]);
      write_coef(sel * 32 + 16 + k, a[k]);
    end
    write_coef(sel * 32 + 9, bias);
  endtask

  // Monitor: pops expected results when done pulses
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected done", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'($signed(y_out)) == e, t, int'($signed(y_out)), e);
      end
    end
  end

  task automatic run(input int sel, input int niter, input int u[9], input int nb[4][8],
                     input int b[9], input int bias, input int a[9], input string tag,
                     input bit poke);
    int cval, y, s;
    int ownv[5];
    int vals[9];
    int outs[4];
    // Expected result (R7, R8, R9, R10)
    cval = bias;
    for (int k = 0; k < 9; k++) cval += b[k] * u[k];
    y = u[0];
    for (int p = 0; p < niter; p++) begin
      ownv[p] = y;
      s = cval + a[0] * y;
      for (int k = 1; k < 9; k++) s += a[k] * nb[p][k-1];
      y = clamp_out(s);
    end
    exp_q.push_back(y);
    tag_q.push_back(tag);

    @(negedge clk);
    start = 1'b1; n_iter = 4'(niter); tmpl_sel = 6'(sel); u_in = 8'(u[0]);
    @(negedge clk);
    start = 1'b0; u_in = 8'h33;
    for (int p = 0; p <= niter; p++) begin
      for (int k = 0; k < 9; k++)
        vals[k] = (p == 0) ? u[k] : ((k == 0) ? ownv[p-1] : nb[p-1][k-1]);
      for (int st = 0; st < 10; st++) begin
        in_n = 8'h5A; in_e = 8'hA5; in_s = 8'h3C; in_w = 8'hC3;
        if (st <= 7) begin
          case (send_side(st))
            0: in_s = 8'(vals[st+1]);
            1: in_w = 8'(vals[st+1]);
            2: in_n = 8'(vals[st+1]);
            default: in_e = 8'(vals[st+1]);
          endcase
        end
        if (poke && p == 0 && st == 3) begin
          start = 1'b1; u_in = 8'h77; tmpl_sel = 6'(sel + 1); n_iter = 4'd0;
        end
        if (poke && p == 0 && st == 4) start = 1'b0;
        // R4/R5: send port carries the value held in this step
        outs[0] = int'($signed(out_n)); outs[1] = int'($signed(out_e));
        outs[2] = int'($signed(out_s)); outs[3] = int'($signed(out_w));
        if (st <= 7) begin
          int side;
          int rest;
          side = send_side(st);
          rest = 0;
          for (int d = 0; d < 4; d++) if (d != side && outs[d] != 0) rest++;
          chk(outs[side] == vals[st] && rest == 0, "R4/R5 send schedule", outs[side], vals[st]);
        end else if (st == 9) begin
          chk((out_n | out_e | out_s | out_w) == 8'd0, "R4 quiet step", 1, 0);
        end
        if (p == niter && st == 9) chk(busy == 1'b1, "R3 busy in last step", int'(busy), 1);
        @(negedge clk);
      end
    end
    chk(done == 1'b1 && busy == 1'b0, "R3 done timing", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R3 done one cycle", int'(done), 0);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!fin) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int ub[9], bA[9], aA[9], bB[9], aB[9], bX[9], aX[9], bS[9], aS[9];
    int uA[9], uX[9];
    int nbA[4][8], nbX[4][8], nbS[4][8];
    rst_n = 1'b0; start = 1'b0; n_iter = '0; tmpl_sel = '0; u_in = '0;
    cw_en = 1'b0; cw_addr = '0; cw_data = '0;
    in_n = '0; in_e = '0; in_s = '0; in_w = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'(busy), 0);
    chk(y_out == 8'd0, "R1 reset y_out", int'(y_out), 0);
    chk((out_n | out_e | out_s | out_w) == 8'd0, "R1 reset outputs", int'(out_n), 0);
    rst_n = 1'b1;
    @(negedge clk);

    uA  = '{40, -20, 10, 30, -50, 60, -70, 80, -90};
    bA  = '{16, -8, 4, -4, 8, -8, 4, -4, 8};
    aA  = '{64, 8, -8, 8, -8, 8, -8, 8, -8};
    bB  = '{-16, 8, -4, 4, -8, 8, -4, 4, -8};
    aB  = '{32, -16, 16, -16, 16, -16, 16, -16, 16};
    nbA = '{'{10, 20, 30, 40, 50, 60, 70, 80},
            '{-5, 15, -25, 35, -45, 55, -65, 75},
            '{100, -100, 90, -90, 80, -80, 70, -70},
            '{0, 0, 0, 0, 0, 0, 0, 0}};
    load_tmpl(3, bA, 32, aA);
    load_tmpl(4, bB, -48, aB);

    // R5 R6 R7 R8: template 3, three feedback passes, start poked mid-run (R2)
    run(3, 3, uA, nbA, bA, 32, aA, "R7 template3 three passes / R2 start ignored", 1'b1);
    // R6: template 4 selected, same inputs
    run(4, 1, uA, nbA, bB, -48, aB, "R6 template4 select", 1'b0);
    // R10: zero feedback passes
    run(3, 0, uA, nbA, bA, 32, aA, "R10 zero iterations", 1'b0);

    // R11: wide intermediate sums cancel to a small value
    for (int k = 0; k < 9; k++) begin uX[k] = -128; bX[k] = 127; aX[k] = -128; end
    for (int p = 0; p < 4; p++) for (int k = 0; k < 8; k++) nbX[p][k] = -128;
    load_tmpl(5, bX, 0, aX);
    run(5, 1, uX, nbX, bX, 0, aX, "R11 wide accumulator", 1'b0);

    // R9: first pass saturates low, second pass uses the clamped own value
    for (int k = 0; k < 9; k++) begin bS[k] = 0; aS[k] = 0; end
    aS[0] = 64; aS[5] = 127;
    for (int p = 0; p < 4; p++) for (int k = 0; k < 8; k++) nbS[p][k] = 0;
    nbS[0][4] = -128; nbS[1][4] = 127;
    ub = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
    load_tmpl(6, bS, -100, aS);
    run(6, 2, ub, nbS, bS, -100, aS, "R9 saturation feeds back", 1'b0);
    run(6, 1, ub, nbS, bS, -100, aS, "R9 negative clamp", 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule